// File: doc/BRIEF.md
# Chained Serial Control Port Reset and Access Gate

This block is the device-side front end of a serial control port on a bus whose devices are chained one behind the other. It watches the command line on the rising edge of the serial clock for a fixed reset frame. When the frame completes, it loads its control registers with their reset values. Every bit arriving on the serial data input is repeated on the serial data output one clock later, so devices further down the chain see the same traffic.

After a reset, register access is locked. The only register that may be touched is the gate register, and the lock opens only when zero is written to it. Any other access while locked is discarded and raises a sticky violation flag. Accesses reach the block as pre-decoded single-cycle requests: a strobe, a write flag, an address and write data. Read data comes back one clock later. All registers are visible in parallel for checking.

Top module: `sio_rst_port`

## Requirements
- R1: A reset frame is 32 consecutive zero bits on `cmd_i` followed by the eight bits 0,0,0,0,1,1,0,0 (first-sent bit first), sampled on rising `sclk`. The reset takes effect on the edge that samples the frame's last bit, and the result is visible right after that edge.
- R2: A frame with fewer than 32 leading zeros, or with any other eight-bit tail, changes no register and no flag.
- R3: `sdo_o` equals the value `sdi_i` had at the previous rising `sclk` edge.
- R4: A reset clears the six registers at addresses 2 through 7 to zero.
- R5: A reset sets the init register (address 0) to 16'h011F: the serial-identifier field, bits 4:0, all ones, the skip bit, bit 8, one, and every other bit zero.
- R6: After a reset `locked_o` is 1. While it is 1, a request to any address other than 1 is dropped: a write leaves the registers unchanged and a read returns 16'h0000 on `rd_data_o`.
- R7: Writing 16'h0000 to the gate register (address 1) clears `locked_o`. From then on reads and writes to every address take effect until the next reset.
- R8: The gate register accepts reads and writes while locked. A nonzero write stores the value and leaves `locked_o` unchanged.
- R9: A dropped request sets `viol_o`. It stays set until the next reset frame, which clears it.
- R10: A reset frame leaves the gate register value unchanged.
- R11: An active-low `rst_n` gives the reset-frame register state with the gate register 0, `viol_o` 0, `sdo_o` 0, and an empty frame history.
- R12: If a request arrives on the same edge that completes a reset frame, the reset wins. The request is discarded and does not set `viol_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, rising edge active |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_i | input | 1 | Serial command line |
| sdi_i | input | 1 | Serial data from the upstream side |
| sdo_o | output | 1 | Serial data repeated to the downstream side |
| req_i | input | 1 | Register access request strobe |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 3 | Register address |
| req_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, one clock after the request, zero otherwise |
| locked_o | output | 1 | Access lock is active |
| viol_o | output | 1 | Sticky flag for a dropped access |
| regs_o | output | 128 | All eight registers, address n in bits 16n+15:16n |

## Verification
Frame detection is tried with exact frames, with frames one zero short, and with frames whose tail differs in the last bit. This separates a detector that counts the zero run correctly from one that only compares the tail. The gate is exercised with blocked writes and reads, a nonzero gate write, and then a zero gate write. This tells "any gate write unlocks" apart from "only a zero write unlocks". A frame whose final edge carries a request checks that reset has priority. Long random command, data and request streams, with frames inserted between them, are checked against a bench model of the lock, the registers and the one-clock repeat.

// File: rtl/sio_rst_pkg.sv
package sio_rst_pkg;
    localparam int DATA_W      = 16;
    localparam int NREG        = 8;
    localparam int ADDR_W      = $clog2(NREG);
    localparam int ZERO_W      = 16;
    localparam int ZERO_FIELDS = 2;
    localparam int OP_W        = 8;
    localparam logic [OP_W-1:0] RST_OP = 8'b0000_1100;
    localparam int INIT_ADDR   = 0;
    localparam int GATE_ADDR   = 1;
    localparam int SID_LSB     = 0;
    localparam int SID_W       = 5;
    localparam int SKIP_BIT    = 8;

    function automatic logic [DATA_W-1:0] init_reset_value();
        logic [DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < SID_W; i++) v[SID_LSB+i] = 1'b1;
        v[SKIP_BIT] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/sio_rst_detect.sv
module sio_rst_detect
    import sio_rst_pkg::*;
#(
    parameter int              P_ZERO_W      = ZERO_W,
    parameter int              P_ZERO_FIELDS = ZERO_FIELDS,
    parameter int              P_OP_W        = OP_W,
    parameter logic [OP_W-1:0] P_OP          = RST_OP
) (
    input  logic sclk,
    input  logic rst_n,
    input  logic cmd_i,
    output logic srst_o
);
    localparam int FRAME_W = P_ZERO_W * P_ZERO_FIELDS + P_OP_W;
    localparam logic [FRAME_W-1:0] PATTERN = {{(FRAME_W-P_OP_W){1'b0}}, P_OP[P_OP_W-1:0]};

    typedef struct packed {
        logic [FRAME_W-1:0] hist;
    } det_t;

    det_t det_d, det_q;
    logic [FRAME_W-1:0] shifted;

    always_comb begin
        det_d   = det_q;
        shifted = {det_q.hist[FRAME_W-2:0], cmd_i};
        srst_o  = (shifted == PATTERN);
        // Refill with ones after a hit so the zero run must be seen again.
        det_d.hist = srst_o ? '1 : shifted;
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) det_q <= '{hist: '1};
        else        det_q <= det_d;
    end

    // R1: a completed frame is acted on once, never on two edges in a row.
    p_single_hit_r1: assert property (@(posedge sclk) disable iff (!rst_n)
        srst_o |=> !srst_o);
endmodule

// File: rtl/sio_repeat.sv
module sio_repeat (
    input  logic sclk,
    input  logic rst_n,
    input  logic sdi_i,
    output logic sdo_o
);
    typedef struct packed {
        logic bit_v;
        logic primed;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d        = rep_q;
        rep_d.bit_v  = sdi_i;
        rep_d.primed = 1'b1;
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign sdo_o = rep_q.bit_v;

    // R3: output follows the input with exactly one clock of delay.
    p_one_clock_r3: assert property (@(posedge sclk) disable iff (!rst_n)
        rep_q.primed |-> (sdo_o == $past(sdi_i)));
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
    import sio_rst_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_NREG   = NREG,
    parameter int P_INIT   = INIT_ADDR,
    parameter int P_GATE   = GATE_ADDR
) (
    input  logic                            sclk,
    input  logic                            rst_n,
    input  logic                            srst_i,
    input  logic                            req_i,
    input  logic                            req_wr_i,
    input  logic [$clog2(P_NREG)-1:0]       req_addr_i,
    input  logic [P_DATA_W-1:0]             req_data_i,
    output logic [P_DATA_W-1:0]             rd_data_o,
    output logic                            locked_o,
    output logic                            viol_o,
    output logic [P_NREG-1:0][P_DATA_W-1:0] regs_o
);
    localparam int AW = $clog2(P_NREG);
    localparam logic [P_DATA_W-1:0] INIT_RST = P_DATA_W'(init_reset_value());

    typedef struct packed {
        logic [P_NREG-1:0][P_DATA_W-1:0] regs;
        logic                            locked;
        logic                            viol;
        logic [P_DATA_W-1:0]             rd;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  allowed;
    logic  is_gate;

    always_comb begin
        bank_d    = bank_q;
        bank_d.rd = '0;
        is_gate   = (req_addr_i == AW'(P_GATE));
        allowed   = !bank_q.locked || is_gate;
        if (srst_i) begin
            for (int i = 0; i < P_NREG; i++) begin
                if (i == P_INIT)      bank_d.regs[i] = INIT_RST;
                else if (i != P_GATE) bank_d.regs[i] = '0;
            end
            bank_d.locked = 1'b1;
            bank_d.viol   = 1'b0;
        end else if (req_i) begin
            if (!allowed) begin
                bank_d.viol = 1'b1;
            end else if (req_wr_i) begin
                bank_d.regs[req_addr_i] = req_data_i;
                if (is_gate && req_data_i == '0) bank_d.locked = 1'b0;
            end else begin
                bank_d.rd = bank_q.regs[req_addr_i];
            end
        end
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < P_NREG; i++)
                bank_q.regs[i] <= (i == P_INIT) ? INIT_RST : '0;
            bank_q.locked <= 1'b1;
            bank_q.viol   <= 1'b0;
            bank_q.rd     <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rd_data_o = bank_q.rd;
    assign locked_o  = bank_q.locked;
    assign viol_o    = bank_q.viol;
    assign regs_o    = bank_q.regs;

    // R6: a locked access to a non-gate address alters no register.
    p_locked_drop_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        (locked_o && req_i && req_addr_i != AW'(P_GATE) && !srst_i)
            |=> ($stable(regs_o) && rd_data_o == '0));

    // R9: a dropped access raises the flag.
    p_viol_set_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        (locked_o && req_i && req_addr_i != AW'(P_GATE) && !srst_i) |=> viol_o);

    // R9: the flag holds until a reset frame.
    p_viol_sticky_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        (viol_o && !srst_i) |=> viol_o);

    // R5: init register reset value and lock after a frame.
    p_init_value_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        srst_i |=> (regs_o[P_INIT] == INIT_RST && locked_o && !viol_o));

    // R10: gate register survives a frame.
    p_gate_kept_r10: assert property (@(posedge sclk) disable iff (!rst_n)
        srst_i |=> $stable(regs_o[P_GATE]));

    // R7: once open, the lock stays open until a frame.
    p_stay_open_r7: assert property (@(posedge sclk) disable iff (!rst_n)
        (!locked_o && !srst_i) |=> !locked_o);

    // R12: a request on a frame edge never raises the flag.
    p_reset_wins_r12: assert property (@(posedge sclk) disable iff (!rst_n)
        (srst_i && req_i) |=> !viol_o);

    genvar g;
    generate
        for (g = 0; g < P_NREG; g++) begin : g_clear
            if (g != P_INIT && g != P_GATE) begin : g_chk
                // R4: each cleared register reads zero after a frame.
                p_cleared_r4: assert property (@(posedge sclk) disable iff (!rst_n)
                    srst_i |=> (regs_o[g] == '0));
            end
        end
    endgenerate
endmodule

// File: rtl/sio_rst_port.sv
module sio_rst_port
    import sio_rst_pkg::*;
(
    input  logic                   sclk,
    input  logic                   rst_n,
    input  logic                   cmd_i,
    input  logic                   sdi_i,
    output logic                   sdo_o,
    input  logic                   req_i,
    input  logic                   req_wr_i,
    input  logic [ADDR_W-1:0]      req_addr_i,
    input  logic [DATA_W-1:0]      req_data_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic                   locked_o,
    output logic                   viol_o,
    output logic [NREG*DATA_W-1:0] regs_o
);
    logic                         srst;
    logic [NREG-1:0][DATA_W-1:0]  regs;

    sio_rst_detect #(
        .P_ZERO_W      (ZERO_W),
        .P_ZERO_FIELDS (ZERO_FIELDS),
        .P_OP_W        (OP_W),
        .P_OP          (RST_OP)
    ) u_detect (
        .sclk   (sclk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_i),
        .srst_o (srst)
    );

    sio_repeat u_repeat (
        .sclk  (sclk),
        .rst_n (rst_n),
        .sdi_i (sdi_i),
        .sdo_o (sdo_o)
    );

    sio_regbank #(
        .P_DATA_W (DATA_W),
        .P_NREG   (NREG),
        .P_INIT   (INIT_ADDR),
        .P_GATE   (GATE_ADDR)
    ) u_bank (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .srst_i     (srst),
        .req_i      (req_i),
        .req_wr_i   (req_wr_i),
        .req_addr_i (req_addr_i),
        .req_data_i (req_data_i),
        .rd_data_o  (rd_data_o),
        .locked_o   (locked_o),
        .viol_o     (viol_o),
        .regs_o     (regs)
    );

    assign regs_o = regs;
endmodule

// File: tb/sio_rst_port_bench.sv
module sio_rst_port_bench;
    logic        sclk = 1'b0;
    logic        rst_n;
    logic        cmd_i, sdi_i, req_i, req_wr_i;
    logic [2:0]  req_addr_i;
    logic [15:0] req_data_i;
    logic        sdo_o, locked_o, viol_o;
    logic [15:0] rd_data_o;
    logic [127:0] regs_o;

    always #5 sclk = ~sclk;

    sio_rst_port u_sio_rst_port (
        .sclk(sclk), .rst_n(rst_n), .cmd_i(cmd_i), .sdi_i(sdi_i), .sdo_o(sdo_o),
        .req_i(req_i), .req_wr_i(req_wr_i), .req_addr_i(req_addr_i),
        .req_data_i(req_data_i), .rd_data_o(rd_data_o), .locked_o(locked_o),
        .viol_o(viol_o), .regs_o(regs_o)
    );

    localparam logic [39:0] FRAME = 40'h00_0000_000C;
    localparam logic [7:0]  TAIL  = 8'b0000_1100;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] m_regs [8];
    logic        m_locked, m_viol, m_sdo;
    logic [15:0] m_rd;
    logic [39:0] m_hist;

    function automatic logic [15:0] init_val();
        return 16'h011F;  // R5: bits 4:0 and bit 8 set
    endfunction

    function automatic logic allowed_fn(logic locked, logic [2:0] addr);
        return !locked || addr == 3'd1;
    endfunction

    function automatic string reg_tag(int i);
        if (i == 0) return "R5";
        if (i == 1) return "R10";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_frame();
        for (int i = 0; i < 8; i++)
            if (i == 0) m_regs[i] = init_val();
            else if (i != 1) m_regs[i] = 16'h0;
        m_locked = 1'b1;
        m_viol   = 1'b0;
    endtask

    task automatic compare_all();
        for (int i = 0; i < 8; i++)
            check(reg_tag(i), {16'h0, regs_o[i*16 +: 16]}, {16'h0, m_regs[i]});
        check("R7 locked", {31'h0, locked_o}, {31'h0, m_locked});
        check("R9 viol", {31'h0, viol_o}, {31'h0, m_viol});
        check("R6 rd_data", {16'h0, rd_data_o}, {16'h0, m_rd});
        check("R3 sdo", {31'h0, sdo_o}, {31'h0, m_sdo});
    endtask

    task automatic tick(input logic c, input logic s, input logic rq, input logic wr,
                        input logic [2:0] a, input logic [15:0] dat, output logic hit);
        logic ok;
        @(negedge sclk);
        cmd_i = c; sdi_i = s; req_i = rq; req_wr_i = wr; req_addr_i = a; req_data_i = dat;
        @(posedge sclk);
        m_sdo  = s;
        m_rd   = 16'h0;
        m_hist = {m_hist[38:0], c};
        hit    = (m_hist == FRAME);
        if (hit) begin
            model_frame();
            m_hist = '1;
        end else if (rq) begin
            ok = allowed_fn(m_locked, a);
            if (!ok) m_viol = 1'b1;
            else if (wr) begin
                m_regs[a] = dat;
                if (a == 3'd1 && dat == 16'h0) m_locked = 1'b0;
            end else m_rd = m_regs[a];
        end
        #2;
        compare_all();
    endtask

    task automatic idle(input logic c);
        logic h;
        tick(c, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, h);
    endtask

    task automatic access(input logic wr, input logic [2:0] a, input logic [15:0] dat);
        logic h;
        tick(1'b0, 1'($urandom), 1'b1, wr, a, dat, h);
    endtask

    // Sends a one, nzero zeros and a tail; the final bit may carry a request.
    task automatic send_frame(input int nzero, input logic [7:0] tail, input logic rq,
                              input logic wr, input logic [2:0] a, input logic [15:0] dat,
                              output logic hit);
        logic h;
        tick(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0, h);
        for (int i = 0; i < nzero; i++) tick(1'b0, 1'($urandom), 1'b0, 1'b0, 3'd0, 16'h0, h);
        for (int i = 7; i > 0; i--) tick(tail[i], 1'($urandom), 1'b0, 1'b0, 3'd0, 16'h0, h);
        tick(tail[0], 1'($urandom), rq, wr, a, dat, hit);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge sclk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic h;
        void'($urandom(32'd2024));
        rst_n = 1'b0; cmd_i = 0; sdi_i = 0; req_i = 0; req_wr_i = 0;
        req_addr_i = 0; req_data_i = 0;
        for (int i = 0; i < 8; i++) m_regs[i] = 16'h0;
        model_frame();
        m_regs[1] = 16'h0; m_sdo = 0; m_rd = 0; m_hist = '1;
        repeat (3) @(posedge sclk);
        @(negedge sclk);
        rst_n = 1'b1;
        #1;
        // R11: power-on state
        check("R11 init reg", {16'h0, regs_o[15:0]}, {16'h0, init_val()});
        check("R11 regs", {16'h0, regs_o[127:112] | regs_o[111:96] | regs_o[31:16]}, 32'h0);
        check("R11 locked", {31'h0, locked_o}, 32'h1);
        check("R11 viol", {31'h0, viol_o}, 32'h0);
        check("R11 sdo", {31'h0, sdo_o}, 32'h0);

        // R6 / R9: blocked write and read
        access(1'b1, 3'd3, 16'hAAAA);
        check("R6 blocked write", {16'h0, regs_o[63:48]}, 32'h0);
        check("R9 viol set", {31'h0, viol_o}, 32'h1);
        access(1'b0, 3'd0, 16'h0);
        check("R6 blocked read", {16'h0, rd_data_o}, 32'h0);

        // R8: nonzero gate write keeps lock
        access(1'b1, 3'd1, 16'h1234);
        check("R8 gate stored", {16'h0, regs_o[31:16]}, 32'h1234);
        check("R8 still locked", {31'h0, locked_o}, 32'h1);
        access(1'b0, 3'd1, 16'h0);
        check("R8 gate read", {16'h0, rd_data_o}, 32'h1234);

        // R7: zero gate write opens
        access(1'b1, 3'd1, 16'h0);
        check("R7 unlocked", {31'h0, locked_o}, 32'h0);
        for (int i = 0; i < 8; i++)
            if (i != 1) access(1'b1, 3'(i), 16'h1100 + 16'(i));
        access(1'b1, 3'd1, 16'h00F0);
        check("R7 open after nonzero gate", {31'h0, locked_o}, 32'h0);
        access(1'b0, 3'd6, 16'h0);
        check("R7 read open", {16'h0, rd_data_o}, 32'h1106);

        // R2: near-miss frames
        send_frame(31, TAIL, 1'b0, 1'b0, 3'd0, 16'h0, h);
        check("R2 short zeros", {31'h0, h} | {16'h0, regs_o[47:32]}, 32'h1102);
        send_frame(32, 8'b0000_1101, 1'b0, 1'b0, 3'd0, 16'h0, h);
        check("R2 bad tail", {16'h0, regs_o[47:32]}, 32'h1102);
        check("R2 still open", {31'h0, locked_o}, 32'h0);

        // R1 / R4 / R5 / R10: real frame
        access(1'b1, 3'd1, 16'h0);
        access(1'b1, 3'd1, 16'h00F0);
        send_frame(32, TAIL, 1'b0, 1'b0, 3'd0, 16'h0, h);
        check("R1 frame seen", {31'h0, h}, 32'h1);
        check("R4 cleared", {16'h0, regs_o[127:112] | regs_o[63:48]}, 32'h0);
        check("R5 init", {16'h0, regs_o[15:0]}, 32'h011F);
        check("R10 gate kept", {16'h0, regs_o[31:16]}, 32'h00F0);
        check("R1 relocked", {31'h0, locked_o}, 32'h1);

        // R9: violation cleared by next frame
        access(1'b0, 3'd4, 16'h0);
        check("R9 set again", {31'h0, viol_o}, 32'h1);
        send_frame(32, TAIL, 1'b0, 1'b0, 3'd0, 16'h0, h);
        check("R9 cleared", {31'h0, viol_o}, 32'h0);

        // R12: request on frame edge
        access(1'b1, 3'd1, 16'h0);
        send_frame(32, TAIL, 1'b1, 1'b1, 3'd2, 16'h0055, h);
        check("R12 write dropped", {16'h0, regs_o[47:32]}, 32'h0);
        check("R12 no viol", {31'h0, viol_o}, 32'h0);
        check("R12 locked", {31'h0, locked_o}, 32'h1);

        // Random traffic, frames mixed in
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 150 == 0) begin
                send_frame(($urandom % 4 == 0) ? 31 : 32, TAIL, 1'($urandom),
                           1'($urandom), 3'($urandom), 16'($urandom), h);
            end else begin
                tick(($urandom % 10 == 0), 1'($urandom), 1'($urandom), 1'($urandom),
                     3'($urandom), ($urandom % 4 == 0) ? 16'h0 : 16'($urandom), h);
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule